// File: doc/BRIEF.md
# Banked multi-write-port register file

This block is the general-purpose register file of a three-wide in-order core. It offers several combinational read ports and several clocked write ports. It is built only from memories that have a single write port each. Every write port has a private bank that only it writes. Inside that bank there is one copy of the array per read port, so each read port has a copy of its own to look into.

A small table of flip-flops records, for every register, the index of the bank that last wrote it. A read uses that table entry to pick the matching bank's copy. Writes that meet on one register in the same cycle are settled by a fixed priority: the lowest-numbered port wins. A hold input and a flush input each stop every write for the cycle in which they are asserted.

The default build has six read ports, three write ports, 32 registers and 64-bit data. The parameters also allow four reads with two writes, two reads with one write, and 64 registers.

Top module: `mwrf_regfile`

## Requirements
- R1: Each read port returns the register selected by its address combinationally. A change of address changes the data with no clock edge in between.
- R2: A write accepted on any write port becomes visible on every read port after the next rising clock edge.
- R3: Reading a register in the same cycle it is written returns the value it held before that write. There is no bypass from write data to read data.
- R4: While hold is 1, no write port changes any register, whatever the write enables are.
- R5: While flush is 1, no write port changes any register, whatever the write enables are.
- R6: When several enabled ports address the same register in one cycle, port 0 beats port 1 and port 1 beats port 2. The register then reads the winning port's data.
- R7: A register last written by port 1 or port 2 reads that port's value, even when a different value was written earlier through another port.
- R8: Reset (active low, asynchronous) points every register back at bank 0. After reset, each register reads the value that port 0 last wrote to it. Stored data is not cleared.
- R9: All read ports work independently. Different addresses on different ports in the same cycle each return their own register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the bank tag table |
| hold | input | 1 | Blocks all writes this cycle |
| flush | input | 1 | Cancels all writes this cycle |
| wr_en | input | NUM_WR | Write enable per write port, port 0 highest priority |
| wr_addr | input | NUM_WR x ADDR_W | Register index per write port |
| wr_data | input | NUM_WR x DATA_W | Write data per write port |
| rd_addr | input | NUM_RD x ADDR_W | Register index per read port |
| rd_data | output | NUM_RD x DATA_W | Combinational read data per read port |

## Verification
The hardest case to reach is a tag that switches between banks while stale copies of the same register still sit in the other banks. The read then depends on both the collision priority and the tag being current. The stimulus narrows the write addresses to four registers in about a third of the random cycles, so three-way and two-way collisions and back-to-back rewrites from different ports are frequent. Every read port is compared against a flat reference array each cycle. A directed sequence writes through ports 1 and 2 and then resets, to show that the bank 0 copies survive and become visible again.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;

   // Width of a bank index for a given number of write ports.
   function automatic int tag_width(input int n_wr);
      return (n_wr <= 1) ? 1 : $clog2(n_wr);
   endfunction

endpackage

// File: rtl/mwrf_write_arb.sv
// Resolves which write ports commit this cycle: global hold/flush gating
// and fixed priority (lower index wins) on same-register collisions.
module mwrf_write_arb #(
   parameter int NUM_WR = 3,
   parameter int ADDR_W = 5
) (
   input  logic                          hold,
   input  logic                          flush,
   input  logic [NUM_WR-1:0]             wr_en,
   input  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr,
   output logic [NUM_WR-1:0]             wr_win
);

   logic commit_ok;
   assign commit_ok = !hold && !flush;

   for (genvar p = 0; p < NUM_WR; p++) begin : g_port
      logic shadowed;
      always_comb begin
         shadowed = 1'b0;
         for (int q = 0; q < p; q++) begin
            if (wr_en[q] && (wr_addr[q] == wr_addr[p])) shadowed = 1'b1;
         end
         wr_win[p] = commit_ok && wr_en[p] && !shadowed;
      end
   end

endmodule

// File: rtl/mwrf_bank.sv
// Storage owned by one write port, replicated once per read port.
// Each copy has one write port and one combinational read port.
module mwrf_bank #(
   parameter int NUM_RD   = 6,
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 64,
   parameter int ADDR_W   = 5
) (
   input  logic                          clk,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             waddr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
   output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

   for (genvar k = 0; k < NUM_RD; k++) begin : g_copy
      logic [DATA_W-1:0] mem [NUM_REGS];

      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata;
      end

      assign rd_data[k] = mem[rd_addr[k]];
   end

endmodule

// File: rtl/mwrf_tag_table.sv
// Per-register record of the bank that holds the live value.
module mwrf_tag_table #(
   parameter int NUM_RD   = 6,
   parameter int NUM_WR   = 3,
   parameter int NUM_REGS = 32,
   parameter int ADDR_W   = 5,
   parameter int TAG_W    = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WR-1:0]             wr_win,
   input  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr,
   input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
   output logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag,
   output logic [NUM_REGS-1:0][TAG_W-1:0] tag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= '0;
      end else begin
         for (int p = 0; p < NUM_WR; p++) begin
            if (wr_win[p]) tag_q[wr_addr[p]] <= TAG_W'(p);
         end
      end
   end

   for (genvar k = 0; k < NUM_RD; k++) begin : g_lookup
      assign rd_tag[k] = tag_q[rd_addr[k]];
   end

endmodule

// File: rtl/mwrf_regfile.sv
// Multi-write-port register file built from single-write banks.
module mwrf_regfile #(
   parameter int NUM_RD   = 6,
   parameter int NUM_WR   = 3,
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 64,
   parameter int ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          hold,
   input  logic                          flush,
   input  logic [NUM_WR-1:0]             wr_en,
   input  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr,
   input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data,
   input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
   output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

   localparam int TAG_W = mwrf_pkg::tag_width(NUM_WR);

   // Elaboration-time parameter checks
   if (NUM_REGS != 32 && NUM_REGS != 64) begin : g_bad_regs
      $error("mwrf_regfile: NUM_REGS must be 32 or 64");
   end
   if (NUM_WR < 1 || NUM_WR > 4) begin : g_bad_wr
      $error("mwrf_regfile: NUM_WR must be 1 to 4");
   end
   if (NUM_RD < 1 || NUM_RD > 8) begin : g_bad_rd
      $error("mwrf_regfile: NUM_RD must be 1 to 8");
   end
   if (ADDR_W != $clog2(NUM_REGS)) begin : g_bad_aw
      $error("mwrf_regfile: ADDR_W must equal clog2(NUM_REGS)");
   end

   logic [NUM_WR-1:0]                         wr_win;
   logic [NUM_WR-1:0][NUM_RD-1:0][DATA_W-1:0] bank_rd;
   logic [NUM_RD-1:0][TAG_W-1:0]              rd_tag;
   logic [NUM_REGS-1:0][TAG_W-1:0]            tag_q;

   mwrf_write_arb #(
      .NUM_WR (NUM_WR),
      .ADDR_W (ADDR_W)
   ) u_arb (
      .hold    (hold),
      .flush   (flush),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_win  (wr_win)
   );

   for (genvar p = 0; p < NUM_WR; p++) begin : g_bank
      mwrf_bank #(
         .NUM_RD   (NUM_RD),
         .NUM_REGS (NUM_REGS),
         .DATA_W   (DATA_W),
         .ADDR_W   (ADDR_W)
      ) u_bank (
         .clk     (clk),
         .we      (wr_win[p]),
         .waddr   (wr_addr[p]),
         .wdata   (wr_data[p]),
         .rd_addr (rd_addr),
         .rd_data (bank_rd[p])
      );
   end

   if (NUM_WR == 1) begin : g_single
      // One bank: no steering needed
      assign tag_q   = '0;
      assign rd_tag  = '0;
      assign rd_data = bank_rd[0];
   end else begin : g_multi
      mwrf_tag_table #(
         .NUM_RD   (NUM_RD),
         .NUM_WR   (NUM_WR),
         .NUM_REGS (NUM_REGS),
         .ADDR_W   (ADDR_W),
         .TAG_W    (TAG_W)
      ) u_tags (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_win  (wr_win),
         .wr_addr (wr_addr),
         .rd_addr (rd_addr),
         .rd_tag  (rd_tag),
         .tag_q   (tag_q)
      );

      for (genvar k = 0; k < NUM_RD; k++) begin : g_rmux
         always_comb begin
            rd_data[k] = bank_rd[0][k];
            for (int p = 1; p < NUM_WR; p++) begin
               if (rd_tag[k] == TAG_W'(p)) rd_data[k] = bank_rd[p][k];
            end
         end
      end
   end

endmodule

// File: rtl/mwrf_regfile_chk.sv
// Checker bound to mwrf_regfile.
module mwrf_regfile_chk #(
   parameter int NUM_WR   = 3,
   parameter int NUM_REGS = 32,
   parameter int ADDR_W   = 5,
   parameter int TAG_W    = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           hold,
   input logic                           flush,
   input logic [NUM_WR-1:0]              wr_en,
   input logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr,
   input logic [NUM_WR-1:0]              wr_win,
   input logic [NUM_REGS-1:0][TAG_W-1:0] tag_q
);

   assert_hold_freezes_tags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(tag_q));

   assert_flush_freezes_tags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> $stable(tag_q));

   assert_port0_always_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[0] && !hold && !flush) |=> (tag_q[$past(wr_addr[0])] == '0));

   assert_tags_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (tag_q == '0));

   for (genvar p = 0; p < NUM_WR; p++) begin : g_p
      assert_tag_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_win[p] |=> (tag_q[$past(wr_addr[p])] == TAG_W'(p)));

      for (genvar q = p + 1; q < NUM_WR; q++) begin : g_q
         assert_single_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_win[p] && wr_win[q]) |-> (wr_addr[p] != wr_addr[q]));
      end
   end

endmodule

bind mwrf_regfile mwrf_regfile_chk #(
   .NUM_WR   (NUM_WR),
   .NUM_REGS (NUM_REGS),
   .ADDR_W   (ADDR_W),
   .TAG_W    (TAG_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hold    (hold),
   .flush   (flush),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_win  (wr_win),
   .tag_q   (tag_q)
);

// File: tb/tb_mwrf_regfile.sv
module tb_mwrf_regfile;

   localparam int NRD  = 6;
   localparam int NWR  = 3;
   localparam int NREG = 32;
   localparam int DW   = 64;
   localparam int AW   = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic hold  = 1'b0;
   logic flush = 1'b0;
   logic [NWR-1:0]         wr_en   = '0;
   logic [NWR-1:0][AW-1:0] wr_addr = '0;
   logic [NWR-1:0][DW-1:0] wr_data = '0;
   logic [NRD-1:0][AW-1:0] rd_addr = '0;
   logic [NRD-1:0][DW-1:0] rd_data;

   mwrf_regfile dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold),
      .flush   (flush),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   logic [DW-1:0] model   [NREG];
   logic [DW-1:0] a_model [NREG];
   int checks = 0;
   int errors = 0;

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_reads(input string tag);
      for (int k = 0; k < NRD; k++) check(tag, rd_data[k], model[rd_addr[k]]);
   endtask

   // Expected effect of one clock edge: lower port index wins.
   function automatic void commit();
      if (!hold && !flush) begin
         for (int p = NWR - 1; p >= 0; p--) begin
            if (wr_en[p]) begin
               model[wr_addr[p]] = wr_data[p];
               if (p == 0) a_model[wr_addr[p]] = wr_data[p];
            end
         end
      end
   endfunction

   // Called at a falling edge with inputs set.
   task automatic step(input string tag, input bit do_check);
      #1;
      if (do_check) check_reads(tag);
      @(posedge clk);
      commit();
      @(negedge clk);
   endtask

   function automatic logic [DW-1:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   task automatic idle();
      wr_en = '0; hold = 1'b0; flush = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Fill every register through port 0
      for (int r = 0; r < NREG; r++) begin
         wr_en = 3'b001; wr_addr[0] = AW'(r); wr_data[0] = rnd64();
         step("fill", 1'b0);
      end
      idle();

      // R1: combinational read, address change with no edge
      rd_addr[0] = AW'(3);
      #1 check("R1 addr 3", rd_data[0], model[3]);
      rd_addr[0] = AW'(7);
      #1 check("R1 addr 7", rd_data[0], model[7]);
      @(negedge clk);

      // R9: six different addresses at once
      for (int k = 0; k < NRD; k++) rd_addr[k] = AW'(k * 5 + 1);
      step("R9 distinct reads", 1'b1);

      // R3 and R2: write reg 4 on port 1 while reading it
      wr_en = 3'b010; wr_addr[1] = AW'(4); wr_data[1] = 64'h1111_2222_3333_4444;
      for (int k = 0; k < NRD; k++) rd_addr[k] = AW'(4);
      #1 check("R3 old value during write", rd_data[2], a_model[4]);
      step("R3 same cycle", 1'b1);
      idle();
      check("R2 new value after edge", rd_data[5], 64'h1111_2222_3333_4444);
      step("R2 all ports", 1'b1);

      // R7: ports 1 and 2 each write a register, then read back
      wr_en = 3'b110;
      wr_addr[1] = AW'(5); wr_data[1] = 64'hB5B5_0000_0000_0005;
      wr_addr[2] = AW'(6); wr_data[2] = 64'hC6C6_0000_0000_0006;
      step("R7 write", 1'b1);
      idle();
      rd_addr[0] = AW'(5); rd_addr[1] = AW'(6);
      #1 check("R7 port1 value", rd_data[0], 64'hB5B5_0000_0000_0005);
      check("R7 port2 value", rd_data[1], 64'hC6C6_0000_0000_0006);
      @(negedge clk);

      // R6: three-way collision on reg 9
      wr_en = 3'b111;
      for (int p = 0; p < NWR; p++) begin wr_addr[p] = AW'(9); wr_data[p] = 64'hA0 + 64'(p); end
      step("R6 collide", 1'b1);
      idle();
      rd_addr[0] = AW'(9);
      #1 check("R6 port0 beats all", rd_data[0], 64'hA0);
      @(negedge clk);
      // R6: port 1 versus port 2 on reg 10
      wr_en = 3'b110;
      wr_addr[1] = AW'(10); wr_data[1] = 64'hB10;
      wr_addr[2] = AW'(10); wr_data[2] = 64'hC10;
      step("R6 collide 1v2", 1'b1);
      idle();
      rd_addr[0] = AW'(10);
      #1 check("R6 port1 beats port2", rd_data[0], 64'hB10);
      @(negedge clk);

      // R4: hold blocks writes
      wr_en = 3'b111; hold = 1'b1;
      for (int p = 0; p < NWR; p++) begin wr_addr[p] = AW'(12 + p); wr_data[p] = rnd64(); end
      step("R4 hold", 1'b1);
      idle();
      for (int p = 0; p < NWR; p++) rd_addr[p] = AW'(12 + p);
      step("R4 unchanged after hold", 1'b1);

      // R5: flush cancels writes
      wr_en = 3'b111; flush = 1'b1;
      for (int p = 0; p < NWR; p++) begin wr_addr[p] = AW'(20 + p); wr_data[p] = rnd64(); end
      step("R5 flush", 1'b1);
      idle();
      for (int p = 0; p < NWR; p++) rd_addr[p] = AW'(20 + p);
      step("R5 unchanged after flush", 1'b1);

      // R8: reset returns reads to the port 0 copies
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int r = 0; r < NREG; r++) model[r] = a_model[r];
      rd_addr[0] = AW'(4); rd_addr[1] = AW'(5); rd_addr[2] = AW'(6);
      rd_addr[3] = AW'(9); rd_addr[4] = AW'(10); rd_addr[5] = AW'(0);
      #1 check("R8 reg5 back to port0 copy", rd_data[1], a_model[5]);
      step("R8 after reset", 1'b1);

      // Random traffic with frequent collisions
      for (int c = 0; c < 4000; c++) begin
         bit narrow;
         narrow = ($urandom % 3) == 0;
         hold   = ($urandom % 10) == 0;
         flush  = ($urandom % 10) == 0;
         wr_en  = NWR'($urandom);
         for (int p = 0; p < NWR; p++) begin
            wr_addr[p] = narrow ? AW'($urandom % 4) : AW'($urandom);
            wr_data[p] = rnd64();
         end
         for (int k = 0; k < NRD; k++) begin
            if (($urandom % 4) == 0) rd_addr[k] = wr_addr[k % NWR];
            else rd_addr[k] = narrow ? AW'($urandom % 4) : AW'($urandom);
         end
         step("R2 R3 R6 R9 random", 1'b1);
      end
      idle();
      step("final", 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule